// File: doc/BRIEF.md
# Dynamic Bus Sizing Controller

This block is the master side of an asynchronous external bus. An internal client asks for a byte, word or long-word transfer at an address. The controller opens a bus cycle with an active-low strobe and waits for the slave. The slave answers on a two-bit active-low acknowledge pair. The code it returns both closes the cycle and reports whether the port is 8 or 16 bits wide. When the operand has not been fully moved, the controller runs more sub-cycles at advancing addresses. On reads it shifts the returned bytes into a result register. On writes it steers the outgoing bytes onto the fixed data lanes.

Every sub-cycle begins on the assumption that the port is 16 bits wide. A slave that answers with the 8-bit code therefore moves only one byte, and the controller follows up one address higher. A reserved acknowledge code, or a slave that makes the controller wait beyond a programmable limit, ends the transfer with an error flag.

The state machine has three states:
- IDLE: waits for a request.
- RUN: the strobe is low and the acknowledge pair is sampled on every clock.
- GAP: the strobe is high for one clock between sub-cycles.

It has these transitions:
- IDLE→RUN: a request is accepted.
- RUN→RUN: the slave asks for a wait and the limit has not been reached.
- RUN→GAP: a sub-cycle completes but bytes remain.
- RUN→IDLE: the last sub-cycle completes, or an error occurs.
- GAP→RUN: the next sub-cycle starts.

Top module: `bus_sizer`

## Requirements
- R1: After reset, bus_strobe_n is 1, bus_dout_en is 0, and both done and err are 0.
- R2: The controller samples bus_ack_n on each clock while the strobe is low. The code 2'b11 holds the cycle open with bus_addr unchanged. The code 2'b10 completes the cycle as an 8-bit port. The code 2'b01 completes the cycle as a 16-bit port.
- R3: req_size is 0 for a byte, 1 for a word and 2 for a long word; the value 3 is treated as a long word. Each sub-cycle moves 2 bytes after the 16-bit code when at least 2 bytes remain, and 1 byte otherwise. The next sub-cycle's address is the previous address plus the bytes moved. A long word therefore takes 2 sub-cycles on a 16-bit port and 4 on an 8-bit port. The strobe is high for one clock between sub-cycles.
- R4: Reads are big-endian: OP0 is at the lowest address and comes first. rd_data holds the operand right-justified, with unused upper bytes 0. An 8-bit port supplies its byte on bus_din[15:8]. A 16-bit port supplies a 2-byte pair on [15:8] (even address) and [7:0] (odd address). A single byte from a 16-bit port is taken from [7:0] when the address is odd and from [15:8] when it is even.
- R5: Write data is right-justified in req_wdata, with OP0 as the most significant byte of the operand. The next byte is driven on bus_dout[15:8] and the byte after it on [7:0]. When bus_single is 1, meaning one byte remains, that byte is driven on both lanes. bus_dout_en is 1 only while the strobe is low in a write.
- R6: done is a one-clock pulse in the clock after the final completion code is sampled. rd_data is valid in that clock.
- R7: The reserved code 2'b00 ends the transfer: done and err pulse together.
- R8: With wait_limit = L, a sub-cycle may sample up to L wait codes. The (L+1)th wait code ends the transfer, with done and err pulsing together.
- R9: req_valid is ignored unless the state machine is IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Start a transfer (taken in IDLE only) |
| req_addr | input | AW | Address of OP0 |
| req_size | input | 2 | 0 byte, 1 word, 2 or 3 long word |
| req_write | input | 1 | 1 write, 0 read |
| req_wdata | input | 32 | Right-justified write operand |
| wait_limit | input | CW | Wait codes allowed per sub-cycle |
| rd_data | output | 32 | Right-justified read operand |
| done | output | 1 | One-clock end-of-transfer pulse |
| err | output | 1 | Error, pulses with done |
| bus_addr | output | AW | External address |
| bus_strobe_n | output | 1 | Active-low cycle strobe |
| bus_read | output | 1 | 1 during read cycles |
| bus_single | output | 1 | Only one byte remains in this sub-cycle |
| bus_dout | output | 16 | Write data lanes |
| bus_dout_en | output | 1 | Write data drive enable |
| bus_din | input | 16 | Read data lanes |
| bus_ack_n | input | 2 | Active-low acknowledge pair |

## Verification
Each operand size is read and written through a slave model that can play an 8-bit port or a 16-bit port. The sub-cycle count and the address sequence show whether the per-cycle width discovery works. Byte reads and writes at odd and even addresses on the 16-bit port show whether the lane choice is right. The 8-bit model drives a marker pattern on the unused low lane, so a wrong lane cannot go unnoticed. Wait counts exactly at the limit and beyond it show the timeout boundary. The reserved code shows the error path. Request pulses during a running transfer show that a request is taken only in IDLE.

// File: rtl/bsz_pkg.sv
package bsz_pkg;
    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_WORD = 2'd1,
        SZ_LONG = 2'd2
    } op_size_e;

    // active-low acknowledge codes, bit 1 is the 16-bit line
    typedef enum logic [1:0] {
        ACK_RSVD = 2'b00,
        ACK_W16  = 2'b01,
        ACK_W8   = 2'b10,
        ACK_WAIT = 2'b11
    } ack_code_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_GAP  = 2'd2
    } bsz_state_e;

    localparam int OP_BYTES = 4;
    localparam int BYTE_W   = 8;

    function automatic logic [2:0] size_bytes(input logic [1:0] sz);
        case (sz)
            SZ_BYTE: return 3'd1;
            SZ_WORD: return 3'd2;
            default: return 3'd4;
        endcase
    endfunction
endpackage

// File: rtl/bsz_wait_timer.sv
module bsz_wait_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          waiting,
    input  logic [CW-1:0] limit,
    output logic          timeout
);
    logic [CW-1:0] cnt;

    assign timeout = run && waiting && (cnt >= limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (run && waiting && !timeout)
            cnt <= cnt + 1'b1;
        else
            cnt <= '0;
    end

    // R8: the count of wait samples never passes the limit
    assert_wait_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= limit);
endmodule

// File: rtl/bsz_wr_lanes.sv
module bsz_wr_lanes (
    input  logic [31:0] wbuf,
    input  logic        single,
    output logic [15:0] lanes
);
    // R5: next byte on the upper lane, the one after on the lower lane
    always_comb begin
        lanes[15:8] = wbuf[31:24];
        lanes[7:0]  = single ? wbuf[31:24] : wbuf[23:16];
    end
endmodule

// File: rtl/bsz_rd_pack.sv
module bsz_rd_pack (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clear,
    input  logic        capture,
    input  logic        two,
    input  logic        lane_lo,
    input  logic [15:0] din,
    output logic [31:0] rbuf
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            rbuf <= '0;
        else if (clear)
            rbuf <= '0;
        else if (capture) begin
            if (two)
                rbuf <= {rbuf[15:0], din};
            else
                rbuf <= {rbuf[23:0], lane_lo ? din[7:0] : din[15:8]};
        end
    end
endmodule

// File: rtl/bus_sizer.sv
module bus_sizer
    import bsz_pkg::*;
#(
    parameter int AW = 24,
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [AW-1:0] req_addr,
    input  logic [1:0]    req_size,
    input  logic          req_write,
    input  logic [31:0]   req_wdata,
    input  logic [CW-1:0] wait_limit,
    output logic [31:0]   rd_data,
    output logic          done,
    output logic          err,
    output logic [AW-1:0] bus_addr,
    output logic          bus_strobe_n,
    output logic          bus_read,
    output logic          bus_single,
    output logic [15:0]   bus_dout,
    output logic          bus_dout_en,
    input  logic [15:0]   bus_din,
    input  logic [1:0]    bus_ack_n
);
    bsz_state_e    state, state_nx;
    logic [AW-1:0] addr_q;
    logic [2:0]    left_q;
    logic [31:0]   wbuf_q;
    logic          write_q;
    logic          done_q, err_q;

    logic       in_run, is8, is16, cmpl, bad, tmo, last, accept;
    logic [2:0] moved;
    logic [2:0] req_n;

    assign in_run = (state == ST_RUN);
    assign is8    = (bus_ack_n == ACK_W8);
    assign is16   = (bus_ack_n == ACK_W16);
    assign cmpl   = in_run && (is8 || is16);
    assign bad    = in_run && (bus_ack_n == ACK_RSVD);
    assign moved  = (is16 && left_q >= 3'd2) ? 3'd2 : 3'd1;
    assign last   = cmpl && (left_q == moved);
    assign accept = (state == ST_IDLE) && req_valid;
    assign req_n  = size_bytes(req_size);

    bsz_wait_timer #(.CW(CW)) i_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (in_run),
        .waiting(bus_ack_n == ACK_WAIT),
        .limit  (wait_limit),
        .timeout(tmo)
    );

    bsz_wr_lanes i_lanes (
        .wbuf  (wbuf_q),
        .single(left_q == 3'd1),
        .lanes (bus_dout)
    );

    bsz_rd_pack i_pack (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (accept),
        .capture(cmpl && !write_q),
        .two    (moved == 3'd2),
        .lane_lo(is16 && addr_q[0] && (moved == 3'd1)),
        .din    (bus_din),
        .rbuf   (rd_data)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= state_nx;
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (req_valid) state_nx = ST_RUN;
            ST_RUN: begin
                if (bad || tmo || last) state_nx = ST_IDLE;
                else if (cmpl)          state_nx = ST_GAP;
            end
            ST_GAP:  state_nx = ST_RUN;
            default: state_nx = ST_IDLE;
        endcase
    end

    // datapath and end-of-transfer flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            left_q  <= '0;
            wbuf_q  <= '0;
            write_q <= 1'b0;
            done_q  <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            done_q <= bad || tmo || last;
            err_q  <= bad || tmo;
            if (accept) begin
                addr_q  <= req_addr;
                left_q  <= req_n;
                write_q <= req_write;
                unique case (req_n)
                    3'd1:    wbuf_q <= {req_wdata[7:0], 24'h0};
                    3'd2:    wbuf_q <= {req_wdata[15:0], 16'h0};
                    default: wbuf_q <= req_wdata;
                endcase
            end else if (cmpl && !last) begin
                addr_q <= addr_q + AW'(moved);
                left_q <= left_q - moved;
                wbuf_q <= (moved == 3'd2) ? {wbuf_q[15:0], 16'h0}
                                          : {wbuf_q[23:0], 8'h0};
            end
        end
    end

    // outputs
    always_comb begin
        bus_addr     = addr_q;
        bus_strobe_n = !in_run;
        bus_read     = !write_q;
        bus_single   = (left_q == 3'd1);
        bus_dout_en  = in_run && write_q;
        done         = done_q;
        err          = err_q;
    end

    // R6: done lasts exactly one clock
    assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R7: err never appears without done
    assert_err_with_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> done);
    // R8: an error follows a reserved or a wait code
    assert_err_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && err) |-> ($past(bus_ack_n) == 2'b00 || $past(bus_ack_n) == 2'b11));
    // R2: address held while the strobe stays low
    assert_addr_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_strobe_n && $past(!bus_strobe_n)) |-> $stable(bus_addr));
    // R3: the strobe is released after every completion code
    assert_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_strobe_n && (bus_ack_n == 2'b01 || bus_ack_n == 2'b10)) |=> bus_strobe_n);
endmodule

// File: tb/test_bus_sizer.sv
`timescale 1ns/1ps
module test_bus_sizer;
    localparam int AW = 24;
    localparam int CW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [1:0]    req_size = '0;
    logic          req_write = 1'b0;
    logic [31:0]   req_wdata = '0;
    logic [CW-1:0] wait_limit = 8'd4;
    logic [31:0]   rd_data;
    logic          done, err;
    logic [AW-1:0] bus_addr;
    logic          bus_strobe_n, bus_read, bus_single, bus_dout_en;
    logic [15:0]   bus_dout;
    logic [15:0]   bus_din = '0;
    logic [1:0]    bus_ack_n = 2'b11;

    always #2.5 clk = ~clk;

    bus_sizer #(.AW(AW), .CW(CW)) i_bus_sizer (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_size(req_size), .req_write(req_write), .req_wdata(req_wdata),
        .wait_limit(wait_limit), .rd_data(rd_data), .done(done), .err(err),
        .bus_addr(bus_addr), .bus_strobe_n(bus_strobe_n), .bus_read(bus_read),
        .bus_single(bus_single), .bus_dout(bus_dout), .bus_dout_en(bus_dout_en),
        .bus_din(bus_din), .bus_ack_n(bus_ack_n)
    );

    int n_checks = 0;
    int n_errs   = 0;

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp, input string what);
        n_checks++;
        if (!ok) begin
            n_errs++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // slave model
    logic [7:0]    mem [16];
    bit            port8 = 0;
    int            slave_wait = 0;
    int            slave_mode = 0; // 0 normal, 1 reserved code, 2 never answers
    int            wcnt = 0;
    int            nsub = 0;
    logic [AW-1:0] sub_addr [8];

    always @(negedge clk) begin
        logic [3:0] a;
        if (!bus_strobe_n) begin
            if (bus_dout_en !== !bus_read)
                check(0, "R5", 32'(bus_dout_en), 32'(!bus_read), "drive enable");
            if (slave_mode != 2 && wcnt >= slave_wait) begin
                if (slave_mode == 1) bus_ack_n = 2'b00;
                else begin
                    bus_ack_n = port8 ? 2'b10 : 2'b01;
                    if (nsub < 8) sub_addr[nsub] = bus_addr;
                    nsub++;
                    a = bus_addr[3:0];
                    if (bus_read)
                        bus_din = port8 ? {mem[a], 8'hA5}
                                        : {mem[{a[3:1], 1'b0}], mem[{a[3:1], 1'b1}]};
                    else if (port8)
                        mem[a] = bus_dout[15:8];
                    else if (bus_single)
                        mem[a] = a[0] ? bus_dout[7:0] : bus_dout[15:8];
                    else begin
                        mem[{a[3:1], 1'b0}] = bus_dout[15:8];
                        mem[{a[3:1], 1'b1}] = bus_dout[7:0];
                    end
                end
            end else bus_ack_n = 2'b11;
            wcnt++;
        end else begin
            bus_ack_n = 2'b11;
            wcnt = 0;
        end
    end

    // scoreboard
    typedef struct {
        logic [31:0] rd;
        logic        e;
        bit          chk_rd;
        string       tag;
    } exp_t;
    exp_t sb[$];
    int   n_done = 0;
    logic prev_done = 1'b0;

    always @(negedge clk) begin
        exp_t x;
        if (rst_n) begin
            if (done && prev_done) check(0, "R6", 32'd1, 32'd0, "done longer than one clock");
            if (done) begin
                n_done++;
                if (sb.size() == 0) check(0, "R9", 32'd1, 32'd0, "unexpected done");
                else begin
                    x = sb.pop_front();
                    check(err === x.e, x.tag, 32'(err), 32'(x.e), "err flag");
                    if (x.chk_rd) check(rd_data === x.rd, x.tag, rd_data, x.rd, "read data");
                end
            end
            prev_done = done;
        end
    end

    function automatic logic [31:0] exp_read(input int addr, input int n);
        logic [31:0] r = '0;
        for (int i = 0; i < n; i++) r = {r[23:0], mem[(addr + i) % 16]};
        return r;
    endfunction

    task automatic xfer(input int addr, input logic [1:0] size, input bit wr,
                        input logic [31:0] wdata, input logic [31:0] erd,
                        input bit eerr, input bit chk_rd, input string tag);
        int start;
        int cnt;
        exp_t x;
        x.rd = erd; x.e = eerr; x.chk_rd = chk_rd; x.tag = tag;
        sb.push_back(x);
        nsub = 0;
        start = n_done;
        @(negedge clk);
        req_valid = 1'b1; req_addr = AW'(addr); req_size = size;
        req_write = wr; req_wdata = wdata;
        @(negedge clk);
        req_valid = 1'b0;
        cnt = 0;
        while (n_done == start && cnt < 500) begin
            @(posedge clk);
            cnt++;
        end
        if (n_done == start) check(0, tag, 32'd0, 32'd1, "transfer never ended");
        @(negedge clk);
    endtask

    task automatic chk_subs(input int base, input int n, input int step, input string tag);
        check(nsub == n, tag, 32'(nsub), 32'(n), "sub-cycle count");
        for (int i = 0; i < n && i < 8; i++)
            check(sub_addr[i] == AW'(base + i * step), tag, 32'(sub_addr[i]),
                  32'(base + i * step), "sub-cycle address");
    endtask

    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_errs++;
            n_checks++;
            $display("FAIL watchdog expired actual=%0d expected<150000", cyc);
            $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 16; i++) mem[i] = 8'(i * 17 + 3);
        repeat (3) @(negedge clk);
        // R1 reset state
        check(bus_strobe_n === 1'b1, "R1", 32'(bus_strobe_n), 32'd1, "strobe");
        check(done === 1'b0, "R1", 32'(done), 32'd0, "done");
        check(err === 1'b0, "R1", 32'(err), 32'd0, "err");
        check(bus_dout_en === 1'b0, "R1", 32'(bus_dout_en), 32'd0, "drive enable");
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R3 R4 long reads
        port8 = 0; xfer(4, 2'd2, 0, 0, exp_read(4, 4), 0, 1, "R4_long16");
        chk_subs(4, 2, 2, "R3_long16");
        port8 = 1; xfer(8, 2'd2, 0, 0, exp_read(8, 4), 0, 1, "R4_long8");
        chk_subs(8, 4, 1, "R3_long8");
        // word reads
        port8 = 0; xfer(2, 2'd1, 0, 0, exp_read(2, 2), 0, 1, "R4_word16");
        chk_subs(2, 1, 2, "R3_word16");
        port8 = 1; xfer(6, 2'd1, 0, 0, exp_read(6, 2), 0, 1, "R4_word8");
        chk_subs(6, 2, 1, "R3_word8");
        // byte reads, lane choice
        port8 = 0; xfer(5, 2'd0, 0, 0, exp_read(5, 1), 0, 1, "R4_byte16_odd");
        xfer(4, 2'd0, 0, 0, exp_read(4, 1), 0, 1, "R4_byte16_even");
        port8 = 1; xfer(3, 2'd0, 0, 0, exp_read(3, 1), 0, 1, "R4_byte8");
        chk_subs(3, 1, 1, "R3_byte8");
        // size code 3 as long word
        port8 = 0; xfer(12, 2'd3, 0, 0, exp_read(12, 4), 0, 1, "R3_size3");
        chk_subs(12, 2, 2, "R3_size3");

        // R5 writes
        port8 = 0; xfer(8, 2'd2, 1, 32'hCAFE_F00D, 0, 0, 0, "R5_long16");
        check({mem[8], mem[9], mem[10], mem[11]} == 32'hCAFE_F00D, "R5",
              {mem[8], mem[9], mem[10], mem[11]}, 32'hCAFE_F00D, "long write 16");
        port8 = 1; xfer(2, 2'd1, 1, 32'h0000_BEEF, 0, 0, 0, "R5_word8");
        check({mem[2], mem[3]} == 16'hBEEF, "R5", 32'({mem[2], mem[3]}), 32'hBEEF, "word write 8");
        chk_subs(2, 2, 1, "R3_wr8");
        port8 = 0; xfer(13, 2'd0, 1, 32'h0000_005A, 0, 0, 0, "R5_byte16_odd");
        check(mem[13] == 8'h5A && mem[12] == 8'(12 * 17 + 3), "R5",
              32'({mem[12], mem[13]}), 32'({8'(12 * 17 + 3), 8'h5A}), "odd byte write 16");
        port8 = 1; xfer(0, 2'd0, 1, 32'h0000_0077, 0, 0, 0, "R5_byte8");
        check(mem[0] == 8'h77, "R5", 32'(mem[0]), 32'h77, "byte write 8");

        // R6 R8 wait states at the limit
        wait_limit = 8'd3; slave_wait = 3; port8 = 0;
        xfer(8, 2'd2, 0, 0, exp_read(8, 4), 0, 1, "R8_at_limit");
        chk_subs(8, 2, 2, "R2_waits");
        // R8 beyond the limit
        slave_mode = 2;
        xfer(4, 2'd2, 0, 0, 0, 1, 0, "R8_timeout");
        check(nsub == 0, "R8", 32'(nsub), 32'd0, "no completion on timeout");
        // R7 reserved code
        slave_mode = 1; slave_wait = 0;
        xfer(4, 2'd1, 0, 0, 0, 1, 0, "R7_reserved");
        slave_mode = 0;

        // R9 requests while busy are ignored
        port8 = 1; slave_wait = 2;
        fork
            xfer(0, 2'd2, 0, 0, exp_read(0, 4), 0, 1, "R9_busy");
            begin
                repeat (4) @(negedge clk);
                for (int k = 0; k < 10; k++) begin
                    req_valid = 1'b1; req_addr = AW'(9); req_size = 2'd0;
                    @(negedge clk);
                end
                req_valid = 1'b0;
            end
        join
        chk_subs(0, 4, 1, "R9_busy");
        repeat (5) @(negedge clk);
        check(sb.size() == 0, "R9", 32'(sb.size()), 32'd0, "pending expectations");

        $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
        $finish;
    end
endmodule